// File: doc/BRIEF.md
# Paged Hardware-Monitor Register Window

This block puts a 256-byte register window in front of a bank of hardware-monitor registers that is organised as 16 pages. A byte-wide host port reaches a page selector, a write-control register and a shared window of offsets. Each offset in the window lands in whichever page the selector currently names. The host opens the window by clearing a seal bit, writes paged registers, and then sets the seal bit again. That rising edge tells the monitor side which pages changed.

The monitor side has its own port with a full page-and-offset address. It can read at any time and write while the seal bit is set. A single paged register, the supply fan duty value, is also driven out on a dedicated output. Host write errors, meaning writes into the window while it is sealed, are caught in a sticky flag.

Top module: `hwm_page_window`

## Requirements
- R1: After synchronous reset the page selector is 0, the seal bit (control offset 0x04, bit 0) reads 1, the error flag is 0, every paged register reads 0x00, `fan_pwm` is 0 and `chg_pages` is 0.
- R2: Offset 0xFF is the page selector. Its low 4 bits pick the page and its upper 4 bits read back as 0. The new page applies to the very next host access.
- R3: While the seal bit is 0, a host write to offsets 0x10..0xFE stores the byte in the selected page. Each page keeps its own copy of an offset.
- R4: A host write to 0x10..0xFE while the seal bit is 1 is dropped and sets the sticky error flag (`seal_err`, control bit 7). A control write with bit 7 set clears the flag.
- R5: A control write that takes the seal bit from 0 to 1 raises `chg_pulse` for exactly one cycle, starting the cycle after the write strobe. Writing 1 when the bit is already 1 gives no pulse.
- R6: With each pulse, `chg_pages` presents a mask with bit p set for every page p that took a host write since the previous pulse. The running mask then restarts empty.
- R7: Host reads of paged registers work whatever the seal bit's value.
- R8: `fan_pwm` follows the register at page 1, offset 0x98, whichever port wrote it. It changes the cycle after the write.
- R9: Offsets 0x00..0x03 and 0x05..0x0F read 0x00, and writes to them change nothing. The control register reads with bit 0 = seal, bit 7 = error and all other bits 0.
- R10: Monitor writes, addressed {page[3:0], offset[7:0]}, are stored only while the seal bit is 1 and are dropped while it is 0. `mon_rdata` shows the addressed register one cycle after `mon_addr`.
- R11: `host_rdata` is loaded one cycle after a `host_rd` strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host byte offset within the window |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, registered |
| mon_addr | input | 12 | Monitor address {page, offset} |
| mon_we | input | 1 | Monitor write strobe |
| mon_wdata | input | 8 | Monitor write data |
| mon_rdata | output | 8 | Monitor read data, one cycle latency |
| chg_pulse | output | 1 | One-cycle data-changed pulse |
| chg_pages | output | 16 | Pages written in the committed batch |
| seal_err | output | 1 | Sticky sealed-write error flag |
| fan_pwm | output | 8 | Supply fan duty value (page 1, offset 0x98) |

## Verification
The bench targets five kinds of failure. The first is a page switch that arrives one access late, which would return the old page's byte right after a selector write. The second is a write that gets through while the window is sealed: the fan output or the read-back would change, and the error flag would stay low. The third is a commit pulse that fires on every write of 1, or lasts two cycles; repeating a set of the seal bit exposes it. The fourth is a mask that is never cleared, which would report earlier pages in a later batch. The last is reset leaving stale storage, which would read back old paged bytes.

// File: rtl/hwm_win_pkg.sv
package hwm_win_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_CTRL  = 2'd1,
    KIND_PSEL  = 2'd2,
    KIND_PAGED = 2'd3
  } reg_kind_e;

  localparam int SEAL_BIT = 0;
  localparam int ERR_BIT  = 7;
endpackage

// File: rtl/hwm_win_decode.sv
module hwm_win_decode
  import hwm_win_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 'h04,
  parameter int PSEL_OFS = 'hFF,
  parameter int WIN_LO   = 'h10,
  parameter int WIN_HI   = 'hFE
) (
  input  logic [ADDR_W-1:0] ofs,
  output reg_kind_e         kind
);
  always_comb begin
    if (ofs == ADDR_W'(CTRL_OFS))
      kind = KIND_CTRL;
    else if (ofs == ADDR_W'(PSEL_OFS))
      kind = KIND_PSEL;
    else if (ofs >= ADDR_W'(WIN_LO) && ofs <= ADDR_W'(WIN_HI))
      kind = KIND_PAGED;
    else
      kind = KIND_NONE;
  end
endmodule

// File: rtl/hwm_win_ctrl.sv
module hwm_win_ctrl
  import hwm_win_pkg::*;
#(
  parameter int PAGE_W = 4,
  localparam int PAGES = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_kind_e         kind,
  input  logic              seal_in,
  input  logic              clr_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q,
  output logic              seal_q,
  output logic              err_q,
  output logic              paged_ok,
  output logic [PAGES-1:0]  dirty_q,
  output logic              pulse_q,
  output logic [PAGES-1:0]  pages_q
);
  logic ctrl_wr, commit, sealed_hit;

  assign ctrl_wr    = we && (kind == KIND_CTRL);
  assign commit     = ctrl_wr && seal_in && !seal_q;
  assign paged_ok   = we && (kind == KIND_PAGED) && !seal_q;
  assign sealed_hit = we && (kind == KIND_PAGED) && seal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      seal_q  <= 1'b1;
      err_q   <= 1'b0;
      dirty_q <= '0;
      pulse_q <= 1'b0;
      pages_q <= '0;
    end else begin
      pulse_q <= commit;
      if (we && kind == KIND_PSEL)
        page_q <= page_in;
      if (ctrl_wr)
        seal_q <= seal_in;
      if (sealed_hit)
        err_q <= 1'b1;
      else if (ctrl_wr && clr_in)
        err_q <= 1'b0;
      if (commit) begin
        pages_q <= dirty_q;
        dirty_q <= '0;
      end else if (paged_ok) begin
        dirty_q <= dirty_q | (PAGES'(1) << page_q);
      end
    end
  end
endmodule

// File: rtl/hwm_win_store.sv
module hwm_win_store #(
  parameter int SA_W   = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << SA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              h_en,
  input  logic [SA_W-1:0]   h_addr,
  input  logic [SA_W-1:0]   m_addr,
  output logic [DATA_W-1:0] h_data,
  output logic [DATA_W-1:0] m_data
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] h_q, m_q;
  logic              h_v, m_v;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en)
      ram[wr_addr] <= wr_data;
    if (h_en)
      h_q <= ram[h_addr];
    m_q <= ram[m_addr];
  end

  // written-since-reset flags stand in for clearing the array
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      h_v <= 1'b0;
      m_v <= 1'b0;
    end else begin
      if (wr_en)
        vld[wr_addr] <= 1'b1;
      if (h_en)
        h_v <= vld[h_addr];
      m_v <= vld[m_addr];
    end
  end

  assign h_data = h_v ? h_q : '0;
  assign m_data = m_v ? m_q : '0;
endmodule

// File: rtl/hwm_page_window.sv
module hwm_page_window
  import hwm_win_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 4,
  parameter int CTRL_OFS = 'h04,
  parameter int PSEL_OFS = 'hFF,
  parameter int WIN_LO   = 'h10,
  parameter int WIN_HI   = 'hFE,
  parameter int FAN_PAGE = 1,
  parameter int FAN_OFS  = 'h98,
  localparam int PAGES   = 1 << PAGE_W,
  localparam int SA_W    = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [SA_W-1:0]   mon_addr,
  input  logic              mon_we,
  input  logic [DATA_W-1:0] mon_wdata,
  output logic [DATA_W-1:0] mon_rdata,
  output logic              chg_pulse,
  output logic [PAGES-1:0]  chg_pages,
  output logic              seal_err,
  output logic [DATA_W-1:0] fan_pwm
);
  localparam int FAN_SA = FAN_PAGE * (1 << ADDR_W) + FAN_OFS;

  reg_kind_e         host_kind, kind_q;
  logic [PAGE_W-1:0] page_q;
  logic              seal_q, paged_ok, mon_ok, wr_en;
  logic [PAGES-1:0]  dirty_q;
  logic [SA_W-1:0]   wr_addr;
  logic [DATA_W-1:0] wr_data, h_data, misc_byte, misc_q;

  hwm_win_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .PSEL_OFS(PSEL_OFS),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_dec (
    .ofs(host_addr), .kind(host_kind)
  );

  hwm_win_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(host_we), .kind(host_kind),
    .seal_in(host_wdata[SEAL_BIT]), .clr_in(host_wdata[ERR_BIT]),
    .page_in(host_wdata[PAGE_W-1:0]),
    .page_q(page_q), .seal_q(seal_q), .err_q(seal_err),
    .paged_ok(paged_ok), .dirty_q(dirty_q),
    .pulse_q(chg_pulse), .pages_q(chg_pages)
  );

  // host and monitor writes are exclusive: the seal bit picks the owner
  assign mon_ok  = mon_we && seal_q;
  assign wr_en   = paged_ok || mon_ok;
  assign wr_addr = paged_ok ? {page_q, host_addr} : mon_addr;
  assign wr_data = paged_ok ? host_wdata : mon_wdata;

  hwm_win_store #(.SA_W(SA_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_en(host_rd), .h_addr({page_q, host_addr}), .m_addr(mon_addr),
    .h_data(h_data), .m_data(mon_rdata)
  );

  always_comb begin
    misc_byte = '0;
    if (host_kind == KIND_CTRL) begin
      misc_byte[SEAL_BIT] = seal_q;
      misc_byte[ERR_BIT]  = seal_err;
    end else if (host_kind == KIND_PSEL) begin
      misc_byte = DATA_W'(page_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= KIND_NONE;
      misc_q  <= '0;
      fan_pwm <= '0;
    end else begin
      if (host_rd) begin
        kind_q <= host_kind;
        misc_q <= misc_byte;
      end
      if (wr_en && wr_addr == SA_W'(FAN_SA))
        fan_pwm <= wr_data;
    end
  end

  assign host_rdata = (kind_q == KIND_PAGED) ? h_data : misc_q;
endmodule

// File: rtl/hwm_page_window_chk.sv
module hwm_page_window_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 4,
  parameter int CTRL_OFS = 'h04,
  parameter int PSEL_OFS = 'hFF,
  parameter int FAN_SA   = 'h198,
  localparam int PAGES   = 1 << PAGE_W,
  localparam int SA_W    = PAGE_W + ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [PAGE_W-1:0] psel_val,
  input logic              clr_bit,
  input logic              chg_pulse,
  input logic              seal_err,
  input logic [DATA_W-1:0] fan_pwm,
  input logic              seal_q,
  input logic [PAGE_W-1:0] page_q,
  input logic [PAGES-1:0]  dirty_q,
  input logic              wr_en,
  input logic [SA_W-1:0]   wr_addr
);
  // R5: the pulse never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |=> !chg_pulse);

  // R5: a pulse comes only with the seal bit having just risen
  a_r5_on_rise: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |-> (seal_q && !$past(seal_q)));

  // R6: the running mask restarts with every commit
  a_r6_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |-> (dirty_q == '0));

  // R4: the error flag stays up until a clearing control write
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (seal_err && !(host_we && host_addr == ADDR_W'(CTRL_OFS) && clr_bit))
    |=> seal_err);

  // R2: a page-select write lands on the next cycle
  a_r2_page_now: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == ADDR_W'(PSEL_OFS)) |=> (page_q == $past(psel_val)));

  // R8: the fan output moves only on a write to its register
  a_r8_fan_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == SA_W'(FAN_SA)) |=> $stable(fan_pwm));
endmodule

bind hwm_page_window hwm_page_window_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
  .CTRL_OFS(CTRL_OFS), .PSEL_OFS(PSEL_OFS), .FAN_SA(FAN_SA)
) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .psel_val(host_wdata[PAGE_W-1:0]), .clr_bit(host_wdata[7]),
  .chg_pulse(chg_pulse), .seal_err(seal_err), .fan_pwm(fan_pwm),
  .seal_q(seal_q), .page_q(page_q), .dirty_q(dirty_q),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/hwm_page_window_bench.sv
module hwm_page_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_addr = '0, host_wdata = '0;
  logic        host_we = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic [11:0] mon_addr = '0;
  logic        mon_we = 1'b0;
  logic [7:0]  mon_wdata = '0, mon_rdata;
  logic        chg_pulse, seal_err;
  logic [15:0] chg_pages;
  logic [7:0]  fan_pwm;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hwm_page_window u_hwm_page_window (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rd(host_rd), .host_rdata(host_rdata),
    .mon_addr(mon_addr), .mon_we(mon_we), .mon_wdata(mon_wdata),
    .mon_rdata(mon_rdata), .chg_pulse(chg_pulse), .chg_pages(chg_pages),
    .seal_err(seal_err), .fan_pwm(fan_pwm)
  );

  // {op, req, addr, data}: op 0 = host write, op 1 = host read and compare
  localparam int NVEC = 17;
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1, 4'd1,  8'hFF, 8'h00},  // R1 page 0 after reset
    {2'd1, 4'd1,  8'h04, 8'h01},  // R1 sealed after reset
    {2'd0, 4'd3,  8'h04, 8'h00},  // open window
    {2'd0, 4'd2,  8'hFF, 8'h03},  // R2 page 3
    {2'd0, 4'd3,  8'h20, 8'hA5},  // R3 store
    {2'd1, 4'd7,  8'h20, 8'hA5},  // R7 read while open
    {2'd0, 4'd2,  8'hFF, 8'hF1},  // R2 upper bits dropped
    {2'd1, 4'd2,  8'hFF, 8'h01},  // R2 reads low bits only
    {2'd1, 4'd3,  8'h20, 8'h00},  // R3 page 1 has its own copy
    {2'd0, 4'd8,  8'h98, 8'h7C},  // R8 fan register
    {2'd0, 4'd9,  8'h05, 8'h55},  // R9 unassigned write
    {2'd1, 4'd9,  8'h05, 8'h00},  // R9 unassigned reads zero
    {2'd0, 4'd5,  8'h04, 8'h01},  // R5 commit
    {2'd1, 4'd7,  8'h98, 8'h7C},  // R7 read while sealed
    {2'd0, 4'd4,  8'h98, 8'h11},  // R4 sealed write
    {2'd1, 4'd4,  8'h98, 8'h7C},  // R4 dropped
    {2'd1, 4'd4,  8'h04, 8'h81}   // R4 error bit 7 plus seal bit 0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic mwr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    mon_we = 1'b1; mon_addr = a; mon_wdata = d;
    @(negedge clk);
    mon_we = 1'b0;
  endtask

  task automatic mrd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    mon_addr = a;
    @(negedge clk);
    d = mon_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 chg_pages", 16'(chg_pages), 16'h0);
    check("R1 fan_pwm", 16'(fan_pwm), 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][21:20] == 2'd0) begin
        hwr(VEC[i][15:8], VEC[i][7:0]);
      end else begin
        hrd(VEC[i][15:8], d);
        check($sformatf("R%0d vec%0d", VEC[i][19:16], i), 16'(d), 16'(VEC[i][7:0]));
      end
    end

    check("R8 fan after batch", 16'(fan_pwm), 16'h7C);
    check("R4 seal_err", 16'(seal_err), 16'h1);
    hwr(8'h04, 8'h81);                        // R4 clear, stays sealed
    hrd(8'h04, d);
    check("R4 cleared", 16'(d), 16'h01);

    // R5 / R6 commit with pages 2 and 5
    hwr(8'h04, 8'h00);
    hwr(8'hFF, 8'h02); hwr(8'h30, 8'h42);
    hwr(8'hFF, 8'h05); hwr(8'h30, 8'h5A);
    hwr(8'h04, 8'h01);
    check("R5 pulse", 16'(chg_pulse), 16'h1);
    check("R6 mask", chg_pages, 16'h0024);
    @(negedge clk);
    check("R5 one cycle", 16'(chg_pulse), 16'h0);
    hwr(8'h04, 8'h01);
    check("R5 no pulse on repeat", 16'(chg_pulse), 16'h0);

    // R2 immediate page switch, R3 per-page storage
    hrd(8'h30, d);
    check("R3 page5", 16'(d), 16'h5A);
    hwr(8'hFF, 8'h02);
    hrd(8'h30, d);
    check("R2 next access page2", 16'(d), 16'h42);
    repeat (3) @(negedge clk);
    check("R11 hold", 16'(host_rdata), 16'h42);

    // R10 monitor port
    mwr(12'h198, 8'h33);
    check("R8 monitor write", 16'(fan_pwm), 16'h33);
    mrd(12'h230, d);
    check("R10 monitor read", 16'(d), 16'h42);
    hwr(8'h04, 8'h00);
    mwr(12'h340, 8'h99);
    mrd(12'h340, d);
    check("R10 dropped while open", 16'(d), 16'h00);
    hwr(8'h04, 8'h01);
    check("R6 mask empty", chg_pages, 16'h0000);

    // R1 reset clears state and storage
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 fan reset", 16'(fan_pwm), 16'h0);
    hrd(8'h04, d);
    check("R1 ctrl reset", 16'(d), 16'h01);
    hrd(8'h30, d);
    check("R1 page0 empty", 16'(d), 16'h00);
    hwr(8'hFF, 8'h05);
    hrd(8'h30, d);
    check("R1 storage cleared", 16'(d), 16'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule